// File: doc/BRIEF.md
# Low-Page Trap and Boot-ROM Overlay Guard

This block sits on one CPU data port, between the core and its memory system, and inspects every request as it goes by. It has two jobs. When the trap is armed, any data-side access (read or write) whose physical address falls in the lowest 4 KiB page raises a one-cycle trap flag, and that access is not passed downstream. Instruction fetches are never trapped. When the overlay is armed, data reads that land in a boot-ROM address window still reach memory, but the word returned to the core is replaced by a programmable 32-bit value.

Downstream memory answers forwarded reads after a fixed number of cycles, set by a parameter. The guard keeps a short pipeline of "substitute this one" marks in step with that latency, so the replacement lines up with the right response. Software sets the guard through a small register port with three registers: trap control, overlay control and overlay value. The selected register reads back one cycle later.

Top module: `lowpage_guard`

## Requirements
- R1: When trap-control bit 0 is 1, a request with req_valid=1 and req_fetch=0 (read or write) whose address is below 0x1000 drives trap=1 in the same cycle and fwd_valid=0.
- R2: A request with req_fetch=1 never raises trap, whatever the address or control setting, and is forwarded (fwd_valid=1).
- R3: With trap-control bit 0 at 0, or for addresses at or above 0x1000, no trap is raised and fwd_valid equals req_valid.
- R4: After reset the register port reads 0x00010000 at select 0 (trap control), 0 at select 1 (overlay control) and 0 at select 2 (overlay value). Select 3 always reads 0. cfg_rdata shows the selected register one cycle after cfg_sel is presented.
- R5: Trap control stores only bit 0 and bit 16, and overlay control stores only bit 0. Writing all ones reads back 0x00010001 and 0x00000001. Bit 16 can be cleared by writing 0 and has no effect on behaviour. The overlay value stores all 32 bits.
- R6: With overlay-control bit 0 set, a forwarded data read (req_write=0, req_fetch=0) inside the boot-ROM window returns the overlay value on rsp_rdata instead of the memory word.
- R7: Instruction fetches inside the window and reads outside the window return the memory word. Writes inside the window are forwarded unchanged.
- R8: With overlay-control bit 0 clear, every response carries the memory word unchanged.
- R9: A trapped access makes no downstream request and therefore produces no response, even when it also lies in the overlay window.
- R10: rsp_valid and rsp_rdata follow mem_rvalid and mem_rdata (or the substituted word) with exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 trap control, 1 overlay control, 2 overlay value, 3 none |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Registered readback of the selected register |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| trap | output | 1 | Low-page data trap, same cycle as the request |
| fwd_valid | output | 1 | Request passed to downstream memory |
| mem_rvalid | input | 1 | Downstream read data valid, MEM_LAT cycles after a forwarded read |
| mem_rdata | input | DW | Downstream read data |
| rsp_valid | output | 1 | Read response to the core |
| rsp_rdata | output | DW | Read data to the core, possibly substituted |

## Verification
The bench builds the guard with a 16-bit address, a memory latency of 2 and an 8 KiB boot-ROM window based at zero. The window therefore covers the trap page plus one more page, and addresses above 0x2000 fall outside both. With the narrow address, a sweep of 1024 addresses at varied byte offsets reaches every page edge (0x0FFF, 0x1000, 0x1FFF, 0x2000). Each address is tried as a data read, a data write and a fetch under all four combinations of trap and overlay enable. This covers the overlap where trap priority over substitution matters.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic [1:0] {
    SEL_TRAP = 2'd0,
    SEL_OVLC = 2'd1,
    SEL_OVLV = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int TRAP_EN_BIT   = 0;
  localparam int TRAP_KEEP_BIT = 16;
  localparam int OVL_EN_BIT    = 0;
  localparam int SEL_W         = 2;
endpackage

// File: rtl/lpg_regs.sv
module lpg_regs
  import lpg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic             trap_en,
  output logic             ovl_en,
  output logic [DW-1:0]    ovl_val
);
  logic keep_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_en  <= 1'b0;
      keep_bit <= 1'b1;
      ovl_en   <= 1'b0;
      ovl_val  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_TRAP: begin
          trap_en  <= cfg_wdata[TRAP_EN_BIT];
          keep_bit <= cfg_wdata[TRAP_KEEP_BIT];
        end
        SEL_OVLC: ovl_en  <= cfg_wdata[OVL_EN_BIT];
        SEL_OVLV: ovl_val <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (cfg_sel)
      SEL_TRAP: begin
        rd_mux[TRAP_EN_BIT]   = trap_en;
        rd_mux[TRAP_KEEP_BIT] = keep_bit;
      end
      SEL_OVLC: rd_mux[OVL_EN_BIT] = ovl_en;
      SEL_OVLV: rd_mux = ovl_val;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/lpg_decode.sv
module lpg_decode #(
  parameter int              AW         = 32,
  parameter longint unsigned PAGE_BYTES = 4096,
  parameter longint unsigned ROM_BASE   = 0,
  parameter longint unsigned ROM_BYTES  = 65536
) (
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic          trap_en,
  input  logic          ovl_en,
  output logic          trap,
  output logic          fwd_valid,
  output logic          ovl_hit
);
  localparam logic [AW:0] PAGE_END = (AW+1)'(PAGE_BYTES);
  localparam logic [AW:0] ROM_LO   = (AW+1)'(ROM_BASE);
  localparam logic [AW:0] ROM_HI   = (AW+1)'(ROM_BASE + ROM_BYTES);

  logic [AW:0] addr_x;
  logic        in_page;
  logic        in_rom;
  logic        data_side;

  always_comb begin
    addr_x    = {1'b0, req_addr};
    in_page   = addr_x < PAGE_END;
    in_rom    = (addr_x >= ROM_LO) && (addr_x < ROM_HI);
    data_side = req_valid && !req_fetch;
    trap      = data_side && trap_en && in_page;
    fwd_valid = req_valid && !trap;
    ovl_hit   = data_side && !req_write && ovl_en && in_rom && !trap;
  end
endmodule

// File: rtl/lpg_resp.sv
module lpg_resp #(
  parameter int DW      = 32,
  parameter int MEM_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovl_hit,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] ovl_val,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [MEM_LAT-1:0] mark;

  generate
    if (MEM_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) mark <= '0;
        else     mark <= ovl_hit;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) mark <= '0;
        else     mark <= {mark[MEM_LAT-2:0], ovl_hit};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= mem_rvalid;
      rsp_rdata <= (mem_rvalid && mark[MEM_LAT-1]) ? ovl_val : mem_rdata;
    end
  end
endmodule

// File: rtl/lowpage_guard.sv
module lowpage_guard
  import lpg_pkg::*;
#(
  parameter int              AW         = 32,
  parameter int              DW         = 32,
  parameter longint unsigned PAGE_BYTES = 4096,
  parameter longint unsigned ROM_BASE   = 0,
  parameter longint unsigned ROM_BYTES  = 65536,
  parameter int              MEM_LAT    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic             req_fetch,
  output logic             trap,
  output logic             fwd_valid,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata
);
  logic          trap_en;
  logic          ovl_en;
  logic [DW-1:0] ovl_val;
  logic          ovl_hit;

  lpg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .trap_en(trap_en), .ovl_en(ovl_en), .ovl_val(ovl_val)
  );

  lpg_decode #(
    .AW(AW), .PAGE_BYTES(PAGE_BYTES), .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES)
  ) u_decode (
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_fetch(req_fetch), .trap_en(trap_en), .ovl_en(ovl_en),
    .trap(trap), .fwd_valid(fwd_valid), .ovl_hit(ovl_hit)
  );

  lpg_resp #(.DW(DW), .MEM_LAT(MEM_LAT)) u_resp (
    .clk(clk), .rst(rst), .ovl_hit(ovl_hit), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ovl_val(ovl_val),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int              AW         = 32,
  parameter int              DW         = 32,
  parameter longint unsigned PAGE_BYTES = 4096
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_fetch,
  input logic [AW-1:0] req_addr,
  input logic          trap,
  input logic          fwd_valid,
  input logic          mem_rvalid,
  input logic [DW-1:0] mem_rdata,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          ovl_en
);
  localparam logic [AW:0] PAGE_END = (AW+1)'(PAGE_BYTES);

  assert_trap_scope_R1: assert property (@(posedge clk) disable iff (rst)
    trap |-> (req_valid && !req_fetch && ({1'b0, req_addr} < PAGE_END)));

  assert_fetch_no_trap_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_fetch) |-> (!trap && fwd_valid));

  assert_trap_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    trap |-> !fwd_valid);

  assert_fwd_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> req_valid);

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |=> rsp_valid);

  assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_rvalid |=> !rsp_valid);

  assert_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rvalid && !ovl_en) |=> (rsp_rdata == $past(mem_rdata)));
endmodule

bind lowpage_guard lpg_checker #(.AW(AW), .DW(DW), .PAGE_BYTES(PAGE_BYTES)) u_lpg_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_fetch(req_fetch),
  .req_addr(req_addr), .trap(trap), .fwd_valid(fwd_valid),
  .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ovl_en(ovl_en)
);

// File: tb/lowpage_guard_bench.sv
`timescale 1ns/1ps
module lowpage_guard_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LAT = 2;
  localparam int PAGE = 4096;
  localparam int WIN = 8192;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_fetch = 1'b0;
  logic          trap, fwd_valid;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lowpage_guard #(
    .AW(AW), .DW(DW), .PAGE_BYTES(PAGE), .ROM_BASE(0), .ROM_BYTES(WIN), .MEM_LAT(LAT)
  ) u_lowpage_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_fetch(req_fetch), .trap(trap), .fwd_valid(fwd_valid),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [DW-1:0] d);
    @(negedge clk);
    cfg_sel = sel;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic access(input logic [AW-1:0] a, input bit wr, input bit fe,
                        input bit tr_en, input bit ov_en, input logic [DW-1:0] ov_val);
    bit exp_trap, exp_ovl, is_read;
    string tag;
    exp_trap = tr_en && !fe && (a < PAGE);
    exp_ovl  = ov_en && !wr && !fe && (a < WIN) && !exp_trap;
    is_read  = !wr && !exp_trap;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_fetch = fe;
    #1;
    if (fe) tag = "R2";
    else if (exp_trap) tag = "R1";
    else tag = "R3";
    chk(tag, {31'd0, trap}, {31'd0, exp_trap});
    chk(tag, {31'd0, fwd_valid}, {31'd0, !exp_trap});
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    if (is_read) begin
      mem_rvalid = 1'b1; mem_rdata = mem_word(a);
    end
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    if (exp_trap) chk("R9", {31'd0, rsp_valid}, 32'd0);
    else          chk("R10", {31'd0, rsp_valid}, {31'd0, is_read});
    if (is_read) begin
      if (exp_ovl)     tag = "R6";
      else if (!ov_en) tag = "R8";
      else             tag = "R7";
      chk(tag, rsp_rdata, exp_ovl ? ov_val : mem_word(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4 reset values and select encoding
    cfg_read(2'd0, rd); chk("R4 trap ctrl reset", rd, 32'h0001_0000);
    cfg_read(2'd1, rd); chk("R4 ovl ctrl reset", rd, 32'h0);
    cfg_read(2'd2, rd); chk("R4 ovl value reset", rd, 32'h0);
    cfg_read(2'd3, rd); chk("R4 unused select", rd, 32'h0);
    // R5 stored bits only
    cfg_write(2'd0, 32'hFFFF_FFFF); cfg_read(2'd0, rd); chk("R5 trap ctrl ones", rd, 32'h0001_0001);
    cfg_write(2'd1, 32'hFFFF_FFFF); cfg_read(2'd1, rd); chk("R5 ovl ctrl ones", rd, 32'h1);
    cfg_write(2'd2, 32'h1234_ABCD); cfg_read(2'd2, rd); chk("R5 ovl value", rd, 32'h1234_ABCD);
    cfg_write(2'd3, 32'hFFFF_FFFF); cfg_read(2'd3, rd); chk("R4 unused after write", rd, 32'h0);
    cfg_write(2'd0, 32'h0000_0001); cfg_read(2'd0, rd); chk("R5 bit16 cleared", rd, 32'h1);
    // R5 bit16 has no effect: trap still behaves with it cleared
    access(16'h0010, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_ABCD);
    // Sweep all enable combinations and access kinds
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit tr, ov;
      logic [DW-1:0] val;
      tr = cfg[0]; ov = cfg[1];
      val = 32'hA5C3_0000 | cfg;
      cfg_write(2'd0, {15'd0, 1'b1, 15'd0, tr});
      cfg_write(2'd1, {31'd0, ov});
      cfg_write(2'd2, val);
      for (int i = 0; i < 1024; i++) begin
        logic [AW-1:0] a;
        a = AW'(i * 64 + (i % 64));
        for (int k = 0; k < 3; k++) begin
          access(a, k == 1, k == 2, tr, ov, val);
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule